// File: doc/BRIEF.md
# Smart Card Character Transceiver with Automatic Repetition

This block moves single characters across the one open-drain I/O line of an asynchronous smart card link, one direction at a time. A character is a low start bit, eight data bits and an even parity bit. The block either sends a byte written into its one-entry transmit buffer, or, while that buffer is empty, receives a character that the card starts on the line. A per-bit timing tick comes from outside at a fixed multiple of the elementary time unit (ETU). The block never generates its own baud rate.

Two signalling conventions are supported. In the direct convention the least significant bit goes first and a high level means 1. In the inverse convention the most significant bit goes first and a low level means 1. The block can repeat characters automatically when parity fails. A receiver that sees bad parity pulls the line low during the guard time. A sender that sees that pulse sends the same character again. Either side gives up after a chosen number of attempts, and the two sides report this failure through different flags.

Sticky status flags report the outcome of each character: transmit done, receive done and parity error. A clear input resets them. A transmit-buffer-empty output shows when a new byte may be written.

Top module: `smc_xcvr`

## Requirements
- R1: Direct convention (`cfg_inverse`=0). Bit slots run from 0 to 9, each lasting one ETU (8 ticks by default). Slot 0 is low. Slots 1 to 8 carry data bits 0 to 7, with a high level meaning 1. Slot 9 carries the XOR of the eight data bits, so the ones count is even.
- R2: Inverse convention (`cfg_inverse`=1). Slots 1 to 8 carry data bits 7 down to 0. Slot 9 carries the parity bit. A low level means 1 in every data and parity slot.
- R3: `tx_empty` is 1 after reset. It is 0 from the cycle after an accepted `tx_wr` until the character ends, either accepted or abandoned. A `tx_wr` while `tx_empty` is 0 is ignored.
- R4: A sent character that is not refused sets `tx_done` and leaves `par_err` clear.
- R5: A received character with correct parity sets `rx_done`, puts the byte on `rx_byte`, and leaves the line released through the guard time.
- R6: With repetition off (`cfg_rep_en`=0), a received character with bad parity sets both `rx_done` and `par_err` and sends no error pulse.
- R7: With repetition off, a sent character refused by the receiver sets `par_err`, leaves `tx_done` at 0, and is not sent again.
- R8: With repetition on, a refused character is sent again. The allowed attempts number 4 when `cfg_five`=0 and 5 when `cfg_five`=1. Refusal of the last attempt sets `par_err` and not `tx_done`. A later acceptance sets `tx_done` only.
- R9: With repetition on, every received character with bad parity causes the line to be held low from 10.5 to 11.5 ETU after its start edge. The flags stay clear until the last allowed attempt (4 or 5) also fails. That attempt sets both `rx_done` and `par_err`. A good character resets the attempt count.
- R10: A character sent in the opposite convention to the configured one sets both `rx_done` and `par_err`.
- R11: `flag_clr` clears `tx_done`, `rx_done` and `par_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| etu_tick | input | 1 | One-cycle pulse, 2^OVS_LOG2 per ETU |
| line_in | input | 1 | Level of the shared I/O line |
| line_drive_low | output | 1 | Pull the open-drain line low |
| tx_wr | input | 1 | Write `tx_byte` into the transmit buffer |
| tx_byte | input | DW | Byte to send |
| cfg_inverse | input | 1 | 0 direct, 1 inverse convention |
| cfg_rep_en | input | 1 | Enable automatic repetition |
| cfg_five | input | 1 | Attempt limit: 0 gives 4, 1 gives 5 |
| flag_clr | input | 1 | Clear the sticky flags |
| tx_empty | output | 1 | Transmit buffer may take a byte |
| tx_done | output | 1 | Character sent and accepted |
| rx_done | output | 1 | Character received |
| par_err | output | 1 | Parity failure or refusal outcome |
| rx_byte | output | DW | Last received byte |

## Verification
All results are counted in ticks from the start edge. A sent slot k occupies ticks 8k to 8k+7 after the block drives the start bit. The refusal is sampled at tick 88, and `tx_done` or `par_err` appears on tick 96, which is also when a repeat begins. For a received character the error pulse runs from about tick 85 to tick 93 of the card's own count. The receive flags are due by tick 93. The bench card model keeps one tick count per character and samples the line and flags only at the ticks where those results are due: mid-slot for data, tick 88 for the error pulse, after tick 96 for the send flags. It polls on falling clock edges, so the block's tick edge and the sample never coincide.

// File: rtl/smc_pkg.sv
package smc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_RX   = 2'd2
    } smc_state_e;
endpackage

// File: rtl/smc_frame_enc.sv
// Builds the line levels of slots 0..DW+1 for one character.
module smc_frame_enc #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          inverse,
    output logic [DW+1:0] levels
);
    assign levels[0] = 1'b0;
    for (genvar i = 0; i < DW; i++) begin : g_slot
        assign levels[i+1] = (inverse ? data[DW-1-i] : data[i]) ^ inverse;
    end
    assign levels[DW+1] = (^data) ^ inverse;
endmodule

// File: rtl/smc_frame_dec.sv
// Recovers the byte and the parity verdict from sampled line levels.
module smc_frame_dec #(
    parameter int DW = 8
) (
    input  logic [DW+1:0] levels,
    input  logic          inverse,
    output logic [DW-1:0] data,
    output logic          parity_ok
);
    logic [DW+1:0] vals;
    assign vals = levels ^ {(DW+2){inverse}};
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign data[i] = inverse ? vals[DW-i] : vals[i+1];
    end
    assign parity_ok = ~^vals[DW+1:1];
endmodule

// File: rtl/smc_xcvr.sv
module smc_xcvr
    import smc_pkg::*;
#(
    parameter int DW       = 8,
    parameter int OVS_LOG2 = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          etu_tick,
    input  logic          line_in,
    output logic          line_drive_low,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_byte,
    input  logic          cfg_inverse,
    input  logic          cfg_rep_en,
    input  logic          cfg_five,
    input  logic          flag_clr,
    output logic          tx_empty,
    output logic          tx_done,
    output logic          rx_done,
    output logic          par_err,
    output logic [DW-1:0] rx_byte
);
    localparam int OVS = 1 << OVS_LOG2;
    localparam int FW  = DW + 2;                  // start, data, parity
    localparam int CW  = $clog2((FW + 2) * OVS);  // frame plus guard
    localparam int BW  = CW - OVS_LOG2;
    localparam logic [CW-1:0]       T_TX_CHK  = CW'((FW + 1) * OVS);
    localparam logic [CW-1:0]       T_TX_END  = CW'((FW + 2) * OVS - 1);
    localparam logic [CW-1:0]       T_RX_EVAL = CW'(FW * OVS + OVS / 2);
    localparam logic [CW-1:0]       T_RX_END  = CW'((FW + 1) * OVS + OVS / 2);
    localparam logic [OVS_LOG2-1:0] PH_MID    = OVS_LOG2'(OVS / 2);
    localparam logic [BW-1:0]       B_PAR     = BW'(FW - 1);

    typedef struct packed {
        smc_state_e     st;
        logic [CW-1:0]  cnt;
        logic [FW-1:0]  txf;      // line levels of the buffered character
        logic           full;
        logic [FW-1:0]  rxl;      // sampled line levels
        logic           errdrv;
        logic           refused;
        logic [2:0]     tx_att;
        logic [2:0]     rx_att;
        logic           txd;
        logic           rxd;
        logic           perr;
        logic [DW-1:0]  rxb;
    } regs_t;

    regs_t q, n;

    logic [FW-1:0]       enc_lv;
    logic [DW-1:0]       dec_data;
    logic                dec_ok;
    logic [BW-1:0]       bidx;
    logic [OVS_LOG2-1:0] phase;
    logic [FW-1:0]       txsh;
    logic [2:0]          last_att;
    logic                in_tx, in_rx;

    smc_frame_enc #(.DW(DW)) u_enc (
        .data(tx_byte), .inverse(cfg_inverse), .levels(enc_lv)
    );
    smc_frame_dec #(.DW(DW)) u_dec (
        .levels(q.rxl), .inverse(cfg_inverse), .data(dec_data), .parity_ok(dec_ok)
    );

    assign bidx     = q.cnt[CW-1:OVS_LOG2];
    assign phase    = q.cnt[OVS_LOG2-1:0];
    assign txsh     = q.txf >> bidx;
    assign last_att = cfg_five ? 3'd4 : 3'd3;
    assign in_tx    = (q.st == ST_TX);
    assign in_rx    = (q.st == ST_RX);

    always_comb begin
        n = q;
        if (flag_clr) begin
            n.txd  = 1'b0;
            n.rxd  = 1'b0;
            n.perr = 1'b0;
        end
        if (tx_wr && !q.full) begin
            n.full = 1'b1;
            n.txf  = enc_lv;
        end
        case (q.st)
            ST_IDLE: begin
                if (etu_tick) begin
                    if (q.full) begin
                        n.st      = ST_TX;
                        n.cnt     = '0;
                        n.tx_att  = '0;
                        n.refused = 1'b0;
                    end else if (!line_in) begin
                        n.st     = ST_RX;
                        n.cnt    = '0;
                        n.rxl    = '0;
                        n.errdrv = 1'b0;
                    end
                end
            end
            ST_TX: begin
                if (etu_tick) begin
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == T_TX_CHK) n.refused = !line_in;
                    if (q.cnt == T_TX_END) begin
                        n.cnt = '0;
                        if (!q.refused) begin
                            n.txd  = 1'b1;
                            n.full = 1'b0;
                            n.st   = ST_IDLE;
                        end else if (!cfg_rep_en || q.tx_att == last_att) begin
                            n.perr = 1'b1;
                            n.full = 1'b0;
                            n.st   = ST_IDLE;
                        end else begin
                            n.tx_att  = q.tx_att + 3'd1;
                            n.refused = 1'b0;
                        end
                    end
                end
            end
            ST_RX: begin
                if (etu_tick) begin
                    n.cnt = q.cnt + 1'b1;
                    if (phase == PH_MID) begin
                        if (bidx == '0) begin
                            if (line_in) n.st = ST_IDLE;   // false start
                        end else if (bidx <= B_PAR) begin
                            n.rxl = q.rxl | (FW'(line_in) << bidx);
                        end
                    end
                    if (q.cnt == T_RX_EVAL) begin
                        n.rxb = dec_data;
                        if (dec_ok) begin
                            n.rxd    = 1'b1;
                            n.rx_att = '0;
                            n.st     = ST_IDLE;
                        end else if (!cfg_rep_en) begin
                            n.rxd    = 1'b1;
                            n.perr   = 1'b1;
                            n.rx_att = '0;
                            n.st     = ST_IDLE;
                        end else begin
                            n.errdrv = 1'b1;
                        end
                    end
                    if (q.cnt == T_RX_END) begin
                        n.errdrv = 1'b0;
                        n.st     = ST_IDLE;
                        if (q.rx_att == last_att) begin
                            n.rxd    = 1'b1;
                            n.perr   = 1'b1;
                            n.rx_att = '0;
                        end else begin
                            n.rx_att = q.rx_att + 3'd1;
                        end
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign line_drive_low = (in_tx && bidx <= B_PAR && !txsh[0]) || (in_rx && q.errdrv);
    assign tx_empty = !q.full;
    assign tx_done  = q.txd;
    assign rx_done  = q.rxd;
    assign par_err  = q.perr;
    assign rx_byte  = q.rxb;
endmodule

// File: rtl/smc_xcvr_chk.sv
module smc_xcvr_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_wr,
    input logic tx_empty,
    input logic tx_done,
    input logic rx_done,
    input logic par_err,
    input logic line_drive_low,
    input logic cfg_rep_en,
    input logic flag_clr,
    input logic in_tx,
    input logic in_rx
);
    a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_empty) |=> !tx_empty);
    a_r3_fill_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(tx_wr));
    a_r4_done_frees_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> tx_empty);
    a_r7_done_not_with_error: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> !$rose(par_err));
    a_r6_no_pulse_without_rep: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rx && line_drive_low) |-> cfg_rep_en);
    a_r5_rx_done_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(in_rx));
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !in_tx && !in_rx) |=> (!tx_done && !rx_done && !par_err));
endmodule

bind smc_xcvr smc_xcvr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_empty(tx_empty),
    .tx_done(tx_done), .rx_done(rx_done), .par_err(par_err),
    .line_drive_low(line_drive_low), .cfg_rep_en(cfg_rep_en),
    .flag_clr(flag_clr), .in_tx(in_tx), .in_rx(in_rx)
);

// File: tb/tb_smc_xcvr.sv
module tb_smc_xcvr;
    localparam int OVS = 8;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic card_low = 1'b0, dut_low, io_w;
    logic tx_wr = 1'b0, cfg_inv = 1'b0, cfg_rep = 1'b0, cfg_five = 1'b0, flag_clr = 1'b0;
    logic [7:0] tx_byte = 8'h00, rx_byte;
    logic tx_empty, tx_done, rx_done, par_err;
    int errors = 0, checks = 0;

    always #10 clk = ~clk;
    always @(negedge clk) tick <= rst_n ? ~tick : 1'b0;
    assign io_w = ~(dut_low | card_low);

    smc_xcvr dut (
        .clk(clk), .rst_n(rst_n), .etu_tick(tick), .line_in(io_w),
        .line_drive_low(dut_low), .tx_wr(tx_wr), .tx_byte(tx_byte),
        .cfg_inverse(cfg_inv), .cfg_rep_en(cfg_rep), .cfg_five(cfg_five),
        .flag_clr(flag_clr), .tx_empty(tx_empty), .tx_done(tx_done),
        .rx_done(rx_done), .par_err(par_err), .rx_byte(rx_byte)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tw();
        @(posedge clk iff tick);
        @(negedge clk);
    endtask

    function automatic logic [9:0] enc(input logic [7:0] d, input bit inv, input bit badpar);
        logic [9:0] lv;
        lv[0] = 1'b0;
        for (int i = 0; i < 8; i++) lv[i+1] = (inv ? d[7-i] : d[i]) ^ inv;
        lv[9] = (^d) ^ badpar ^ inv;
        return lv;
    endfunction

    function automatic logic [7:0] dec(input logic [9:0] lv, input bit inv);
        logic [7:0] d;
        for (int i = 0; i < 8; i++) begin
            if (inv) d[7-i] = lv[i+1] ^ inv;
            else     d[i]   = lv[i+1];
        end
        return d;
    endfunction

    task automatic flags(input logic t, input logic r, input logic p, input string req);
        chk(tx_done == t && rx_done == r && par_err == p, req,
            {tx_done, rx_done, par_err}, {t, r, p});
    endtask

    task automatic clr();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic write(input logic [7:0] b);
        @(negedge clk) begin tx_byte = b; tx_wr = 1'b1; end
        @(negedge clk) tx_wr = 1'b0;
    endtask

    // Card sends a frame; reports whether the error pulse was seen at 11 ETU.
    task automatic card_send(input logic [9:0] lv, input bit exp_err, input string req);
        for (int b = 0; b < 10; b++) begin
            card_low = ~lv[b];
            repeat (OVS) tw();
        end
        card_low = 1'b0;
        repeat (OVS) tw();
        chk(io_w == !exp_err, req, io_w, !exp_err);
        repeat (2 * OVS) tw();
    endtask

    // Card receives a frame from the block, optionally refusing it.
    task automatic card_recv(input bit refuse, output logic [9:0] lv, output bit seen);
        int guard = 0;
        lv = '0;
        seen = 1'b0;
        while (io_w && guard < 40 * OVS) begin tw(); guard++; end
        if (io_w) return;
        seen = 1'b1;
        for (int k = 1; k <= 12 * OVS; k++) begin
            tw();
            if (k % OVS == OVS / 2 && k / OVS <= 9) lv[k/OVS] = io_w;
            if (refuse && k == 10 * OVS + OVS / 2) card_low = 1'b1;
            if (k == 11 * OVS + OVS / 2) card_low = 1'b0;
        end
    endtask

    task automatic quiet(input string req);
        bit low = 1'b0;
        for (int k = 0; k < 3 * OVS; k++) begin tw(); if (!io_w) low = 1'b1; end
        chk(!low, req, low, 0);
    endtask

    task automatic t_reset();
        chk(tx_empty == 1'b1, "R3 reset empty", tx_empty, 1);
        flags(0, 0, 0, "R11 reset flags");
        chk(dut_low == 1'b0, "R1 reset line", dut_low, 0);
    endtask

    task automatic t_tx_good(input logic [7:0] b, input bit inv, input string req);
        logic [9:0] lv; bit seen;
        cfg_inv = inv; cfg_rep = 1'b0;
        write(b);
        chk(tx_empty == 1'b0, "R3 buffer full", tx_empty, 0);
        write(~b);                       // ignored: buffer full (R3)
        card_recv(1'b0, lv, seen);
        chk(lv == enc(b, inv, 1'b0), req, lv, enc(b, inv, 1'b0));
        chk(dec(lv, inv) == b, req, dec(lv, inv), b);
        flags(1, 0, 0, "R4 done no error");
        chk(tx_empty == 1'b1, "R3 empty after send", tx_empty, 1);
        quiet("R3 second write ignored");
        clr();
        flags(0, 0, 0, "R11 clear");
    endtask

    task automatic t_rx(input logic [7:0] b, input bit card_inv, input bit badpar,
                        input logic r, input logic p, input string req);
        card_send(enc(b, card_inv, badpar), 1'b0, req);
        flags(0, r, p, req);
        if (!badpar && card_inv == cfg_inv) chk(rx_byte == b, req, rx_byte, b);
        clr();
    endtask

    task automatic t_rx_rep(input bit five);
        int n = five ? 5 : 4;
        cfg_inv = 1'b0; cfg_rep = 1'b1; cfg_five = five;
        for (int a = 1; a <= n; a++) begin
            card_send(enc(8'h96, 1'b0, 1'b1), 1'b1, "R9 error pulse");
            if (a < n) flags(0, 0, 0, "R9 no flag before limit");
        end
        flags(0, 1, 1, "R9 flags at limit");
        clr();
        card_send(enc(8'h21, 1'b0, 1'b1), 1'b1, "R9 pulse then recover");
        card_send(enc(8'h21, 1'b0, 1'b0), 1'b0, "R9 good after bad");
        flags(0, 1, 0, "R9 recovered");
        chk(rx_byte == 8'h21, "R9 data", rx_byte, 8'h21);
        clr();
    endtask

    task automatic t_tx_refuse(input bit rep, input bit five, input int refusals,
                               input int exp_att, input logic t, input logic p, input string req);
        logic [9:0] lv; bit seen; int att = 0;
        cfg_inv = 1'b0; cfg_rep = rep; cfg_five = five;
        write(8'h3C);
        for (int a = 0; a < 8; a++) begin
            card_recv(a < refusals, lv, seen);
            if (!seen) break;
            att++;
            chk(lv == enc(8'h3C, 1'b0, 1'b0), req, lv, enc(8'h3C, 1'b0, 1'b0));
            if (tx_empty) break;
        end
        chk(att == exp_att, req, att, exp_att);
        flags(t, 0, p, req);
        quiet(req);
        clr();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_tx_good(8'hA5, 1'b0, "R1 direct frame");
        t_tx_good(8'h3C, 1'b1, "R2 inverse frame");
        cfg_inv = 1'b0; cfg_rep = 1'b0;
        t_rx(8'h5A, 1'b0, 1'b0, 1, 0, "R5 rx direct");
        cfg_inv = 1'b1;
        t_rx(8'hC3, 1'b1, 1'b0, 1, 0, "R5 rx inverse");
        cfg_inv = 1'b0;
        t_rx(8'h77, 1'b0, 1'b1, 1, 1, "R6 rx bad no rep");
        t_rx(8'h35, 1'b1, 1'b0, 1, 1, "R10 convention mismatch");
        t_rx_rep(1'b0);
        t_tx_refuse(1'b0, 1'b0, 8, 1, 0, 1, "R7 refused no rep");
        t_tx_refuse(1'b1, 1'b1, 8, 5, 0, 1, "R8 five refusals");
        t_tx_refuse(1'b1, 1'b0, 8, 4, 0, 1, "R8 four refusals");
        t_tx_refuse(1'b1, 1'b0, 1, 2, 1, 0, "R8 accepted on retry");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule